// File: doc/BRIEF.md
# Byte-wide SPI Controller with Mode-Fault Handling

This block is a byte-oriented serial peripheral interface engine that works either as the clock-driving master or as a clocked slave. Software sets it up and moves data through a small register port with three addresses: a control byte, a control-status byte and a data byte. Writing the data byte loads the transmit shifter. In master mode that write also starts an eight-bit full-duplex exchange. Reading the data byte returns the last byte received. In master mode the serial clock is made from the system clock through a divider with six settings. In slave mode the serial clock, the incoming data and the slave-select input are brought into the system clock domain by two flip-flops each, and their edges are detected there.

The design guards against a second master on the bus. If slave-select falls while the block is master, hardware takes it out of master mode, disconnects it from the pins and raises a fault flag. The block has one interrupt output, driven by the completion flag and the fault flag. The register port is not a stream, so it applies no back-pressure: every write is taken in the cycle it is presented, and a data write that arrives during a transfer is flagged and dropped.

Top module: `spi_ctl`

## Requirements
- R1: After reset the control byte and the control-status byte read 00h and the data byte reads 00h. The clock, MOSI and MISO output enables are low and the interrupt is low.
- R2: Address 0 is the control byte. From bit 7 down it holds interrupt enable, pin enable, divider bypass, master select, clock polarity, clock phase and rate bits 1:0. It reads back what was written, except for bits that hardware has cleared.
- R3: Address 1 is the control-status byte. From bit 7 down it holds transfer complete, write collision, overrun, mode fault, a constant 0, serial-output disable, software-select enable and software-select value. Writing 1 to any of bits 7..4 clears that flag. Writing 0 leaves it unchanged. Bits 2..0 take the written value. A flag that hardware sets in the same cycle stays set.
- R4: In master mode the SCK period, in system clocks, is chosen by the code {control bit 5, bit 1, bit 0}: 100→2, 000→4, 110→8, 001→16, 010→32, 011→64. The codes 101 and 111 also give 64.
- R5: When no transfer is in progress, SCK rests at the clock-polarity level. The SCK output enable is high only when the block is master with pins enabled.
- R6: A transfer exchanges eight bits, MSB first, in both directions. With phase 0, data is captured on the first SCK edge of each bit. With phase 1, it is captured on the second edge. All four polarity/phase modes work between a master and a slave. In slave mode the rate bits have no effect.
- R7: Completing a byte sets transfer complete. The interrupt is high exactly while interrupt enable is 1 and transfer complete or mode fault is 1.
- R8: A data write during a transfer sets write collision and is discarded. The byte on the wire is not changed.
- R9: A byte that completes while transfer complete is already set sets overrun and leaves the received byte unchanged.
- R10: While master, a low effective slave-select clears master select and pin enable, sets mode fault, and stops any transfer. The effective slave-select is the software value when software select is enabled, and the synchronized pin otherwise.
- R11: Serial-output disable forces the data output enable low. A slave drives MISO only while its pins are enabled and it is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Slave-select pin, active low |
| irq | output | 1 | Interrupt request |

## Verification
Each kind of wrong internal state shows at the ports at a known time:

- **Bit counter.** An error here appears at the end of the byte. The completion flag rises a whole bit early or late, or the received byte comes back rotated, and a read of the data byte after the completion flag exposes it.
- **Divider.** An error shows on sck_o within two SCK periods as a wrong count of system clocks between rising edges.
- **Mode fault.** Mishandling shows within three clocks of slave-select falling, as a control byte that still has master select set, or as SCK still toggling.
- **Flags.** An overrun or collision handled wrongly shows on the next status read, as a received byte that was overwritten.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int BYTE_W    = 8;
  localparam int DIV_W     = 5;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);
  localparam int SYNC_N    = 3;

  typedef struct packed {
    logic       ie;
    logic       spe;
    logic       nodiv;
    logic       mstr;
    logic       cpol;
    logic       cpha;
    logic [1:0] spr;
  } ctrl_t;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } addr_e;

  // system clocks per SCK half period, minus one
  function automatic logic [DIV_W-1:0] half_limit(input logic [2:0] code);
    case (code)
      3'b100:  half_limit = DIV_W'(0);
      3'b000:  half_limit = DIV_W'(1);
      3'b110:  half_limit = DIV_W'(3);
      3'b001:  half_limit = DIV_W'(7);
      3'b010:  half_limit = DIV_W'(15);
      default: half_limit = DIV_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/spi_ctl_clkgen.sv
module spi_ctl_clkgen
  import spi_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] rate,
  output logic       tog,
  output logic       ph
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim = half_limit(rate);
  assign tog = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (tog) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n) !run |=> !ph); // R5
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (run && !tog) |=> $stable(ph)); // R4
endmodule

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mstr,
  input  logic              cpha,
  input  logic              lead,
  input  logic              trail,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              go,
  input  logic              abort,
  input  logic              sin,
  output logic              sout,
  output logic              done,
  output logic              busy,
  output logic [BYTE_W-1:0] done_byte
);
  logic [BYTE_W-1:0]    tx_sh;
  logic [BYTE_W-1:0]    rx_sh;
  logic [BIT_CNT_W-1:0] bits;
  logic [BIT_CNT_W-1:0] bits_nxt;
  logic                 act;
  logic                 sample_ev;
  logic                 shift_ev;

  // a slave becomes active on the first leading edge it sees
  assign act       = !abort && (busy || (!mstr && lead));
  assign sample_ev = act && (cpha ? trail : lead);
  assign shift_ev  = act && (cpha ? (lead && (bits != '0)) : trail);
  assign bits_nxt  = bits + BIT_CNT_W'(sample_ev);
  assign done      = act && (bits_nxt == BIT_CNT_W'(BYTE_W)) && (mstr ? trail : sample_ev);
  assign done_byte = sample_ev ? {rx_sh[BYTE_W-2:0], sin} : rx_sh;
  assign sout      = tx_sh[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      bits  <= '0;
      busy  <= 1'b0;
    end else begin
      if (load)          tx_sh <= load_data;
      else if (shift_ev) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      if (sample_ev)     rx_sh <= {rx_sh[BYTE_W-2:0], sin};
      if (abort || done) begin
        busy <= 1'b0;
        bits <= '0;
      end else begin
        if (go || act)   busy <= 1'b1;
        if (sample_ev)   bits <= bits_nxt;
      end
    end
  end

  AST_DONE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R6
  AST_BITS_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) bits <= BIT_CNT_W'(BYTE_W)); // R6
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] done_byte,
  input  logic              fault,
  output ctrl_t             ctrl,
  output logic              sod,
  output logic              ssm,
  output logic              ssi,
  output logic              load,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);
  logic              tc, wcol, ovr, modf;
  logic [BYTE_W-1:0] rx_buf;
  logic              wr_ctrl, wr_stat, wr_data;

  assign wr_ctrl = wr && (addr == ADDR_CTRL);
  assign wr_stat = wr && (addr == ADDR_STAT);
  assign wr_data = wr && (addr == ADDR_DATA);
  assign load    = wr_data && !busy;
  assign irq     = ctrl.ie && (tc || modf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      tc     <= 1'b0;
      wcol   <= 1'b0;
      ovr    <= 1'b0;
      modf   <= 1'b0;
      sod    <= 1'b0;
      ssm    <= 1'b0;
      ssi    <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata);
      if (wr_stat) begin
        tc   <= tc   & ~wdata[7];
        wcol <= wcol & ~wdata[6];
        ovr  <= ovr  & ~wdata[5];
        modf <= modf & ~wdata[4];
        sod  <= wdata[2];
        ssm  <= wdata[1];
        ssi  <= wdata[0];
      end
      // hardware events override a same-cycle software write
      if (wr_data && busy) wcol <= 1'b1;
      if (fault) begin
        ctrl.mstr <= 1'b0;
        ctrl.spe  <= 1'b0;
        modf      <= 1'b1;
      end
      if (done) begin
        tc <= 1'b1;
        if (tc) ovr    <= 1'b1;
        else    rx_buf <= done_byte;
      end
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rdata = ctrl;
      ADDR_STAT: rdata = {tc, wcol, ovr, modf, 1'b0, sod, ssm, ssi};
      ADDR_DATA: rdata = rx_buf;
      default:   rdata = '0;
    endcase
  end

  AST_FAULT_ACTION: assert property (@(posedge clk) disable iff (!rst_n) fault |=> (!ctrl.mstr && !ctrl.spe && modf)); // R10
  AST_OVR_KEEPS:    assert property (@(posedge clk) disable iff (!rst_n) (done && tc) |=> (ovr && $stable(rx_buf))); // R9
  AST_WCOL_FLAG:    assert property (@(posedge clk) disable iff (!rst_n) (wr_data && busy) |=> wcol); // R8
  AST_TC_ON_DONE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> tc); // R7
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n_i,
  output logic              irq
);
  ctrl_t             ctrl;
  logic              sod, ssm, ssi, load;
  logic              busy, done, sout, tog, ph;
  logic [BYTE_W-1:0] done_byte;
  logic [SYNC_N-1:0] meta_q, sync_q;
  logic              sck_s, mosi_s, ss_s, sck_d;
  logic              ss_low, fault, slave_sel, go, abort, sin;
  logic              m_lead, m_trail, s_lead, s_trail, lead, trail;

  // two-stage synchronizers for the slave-side inputs {sck, mosi, ss_n}
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= SYNC_N'(1);
      sync_q <= SYNC_N'(1);
      sck_d  <= 1'b0;
    end else begin
      meta_q <= {sck_i, mosi_i, ss_n_i};
      sync_q <= meta_q;
      sck_d  <= sync_q[2];
    end
  end
  assign sck_s  = sync_q[2];
  assign mosi_s = sync_q[1];
  assign ss_s   = sync_q[0];

  assign ss_low    = ssm ? !ssi : !ss_s;
  assign fault     = ctrl.mstr && ss_low;
  assign slave_sel = ctrl.spe && !ctrl.mstr && ss_low;
  assign go        = load && ctrl.mstr && ctrl.spe && !fault;
  assign abort     = fault || !ctrl.spe || (!ctrl.mstr && !ss_low);

  assign m_lead  = tog && !ph;
  assign m_trail = tog && ph;
  assign s_lead  = slave_sel && (sck_s != sck_d) && (sck_d == ctrl.cpol);
  assign s_trail = slave_sel && (sck_s != sck_d) && (sck_s == ctrl.cpol);
  assign lead    = ctrl.mstr ? m_lead  : s_lead;
  assign trail   = ctrl.mstr ? m_trail : s_trail;
  assign sin     = ctrl.mstr ? miso_i  : mosi_s;

  spi_ctl_regs regs_i (
    .clk, .rst_n,
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy, .done, .done_byte, .fault,
    .ctrl, .sod, .ssm, .ssi, .load,
    .rdata(reg_rdata), .irq
  );

  spi_ctl_clkgen clkgen_i (
    .clk, .rst_n,
    .run(busy && ctrl.mstr),
    .rate({ctrl.nodiv, ctrl.spr}),
    .tog, .ph
  );

  spi_ctl_shift shift_i (
    .clk, .rst_n,
    .mstr(ctrl.mstr), .cpha(ctrl.cpha),
    .lead, .trail,
    .load, .load_data(reg_wdata), .go, .abort,
    .sin, .sout, .done, .busy, .done_byte
  );

  assign sck_o   = ctrl.cpol ^ ph;
  assign sck_oe  = ctrl.spe && ctrl.mstr;
  assign mosi_o  = sout;
  assign mosi_oe = ctrl.spe && ctrl.mstr && !sod;
  assign miso_o  = sout;
  assign miso_oe = slave_sel && !sod;

  AST_PINS_OFF:    assert property (@(posedge clk) disable iff (!rst_n) !ctrl.spe |-> (!sck_oe && !mosi_oe && !miso_oe)); // R11
  AST_SCK_AT_REST: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !$past(busy)) |-> (sck_o == ctrl.cpol)); // R5
endmodule

// File: tb/spi_ctl_tb_top.sv
module spi_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       m_wr = 0, s_wr = 0;
  logic [1:0] m_addr = 0, s_addr = 0;
  logic [7:0] m_wdata = 0, s_wdata = 0, m_rdata, s_rdata;
  logic       m_sck_o, m_sck_oe, m_mosi_o, m_mosi_oe, m_miso_o, m_miso_oe, m_irq;
  logic       s_sck_o, s_sck_oe, s_mosi_o, s_mosi_oe, s_miso_o, s_miso_oe, s_irq;
  logic       mss_n = 1'b1, sss_n = 1'b1;
  logic       m_miso_in;

  int checks = 0, errors = 0;
  bit finished = 0;

  assign m_miso_in = s_miso_oe ? s_miso_o : 1'b0;

  spi_ctl dut_i (
    .clk, .rst_n, .reg_wr(m_wr), .reg_addr(m_addr), .reg_wdata(m_wdata), .reg_rdata(m_rdata),
    .sck_i(1'b0), .sck_o(m_sck_o), .sck_oe(m_sck_oe),
    .mosi_i(1'b0), .mosi_o(m_mosi_o), .mosi_oe(m_mosi_oe),
    .miso_i(m_miso_in), .miso_o(m_miso_o), .miso_oe(m_miso_oe),
    .ss_n_i(mss_n), .irq(m_irq)
  );

  spi_ctl peer_i (
    .clk, .rst_n, .reg_wr(s_wr), .reg_addr(s_addr), .reg_wdata(s_wdata), .reg_rdata(s_rdata),
    .sck_i(m_sck_o), .sck_o(s_sck_o), .sck_oe(s_sck_oe),
    .mosi_i(m_mosi_o), .mosi_o(s_mosi_o), .mosi_oe(s_mosi_oe),
    .miso_i(1'b0), .miso_o(s_miso_o), .miso_oe(s_miso_oe),
    .ss_n_i(sss_n), .irq(s_irq)
  );

  function automatic int exp_div(input logic [2:0] code);
    case (code)
      3'b100:  return 2;
      3'b000:  return 4;
      3'b110:  return 8;
      3'b001:  return 16;
      3'b010:  return 32;
      default: return 64;
    endcase
  endfunction

  function automatic logic [7:0] ctrl_byte(input logic ie, input logic spe, input logic [2:0] code,
                                           input logic mstr, input logic cpol, input logic cpha);
    return {ie, spe, code[2], mstr, cpol, cpha, code[1:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit s, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (s) begin s_wr = 1; s_addr = a; s_wdata = d; end
    else   begin m_wr = 1; m_addr = a; m_wdata = d; end
    @(negedge clk);
    m_wr = 0; s_wr = 0;
  endtask

  task automatic rd(input bit s, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    if (s) s_addr = a; else m_addr = a;
    #1;
    d = s ? s_rdata : m_rdata;
  endtask

  task automatic wait_tc_m(input string req);
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(0, 2'd1, v);
      if (v[7]) return;
    end
    chk(req, 32'd0, 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int unsigned tmo = 150000;
    repeat (tmo) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(0, 2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(0, 2'd1, v); chk("R1 status", v, 8'h00);
    rd(0, 2'd2, v); chk("R1 data", v, 8'h00);
    chk("R1 enables", {m_sck_oe, m_mosi_oe, m_miso_oe, m_irq}, 4'h0);

    // R2 control readback
    wr(0, 2'd0, 8'h2D); rd(0, 2'd0, v); chk("R2 readback", v, 8'h2D);
    // R3 status: bit 3 reads 0, low bits follow writes
    wr(0, 2'd1, 8'h0F); rd(0, 2'd1, v); chk("R3 low bits", v, 8'h07);
    wr(0, 2'd0, 8'h00);

    // R4 every rate code, measured between two SCK rising edges
    wr(0, 2'd1, 8'h03);
    for (int c = 0; c < 8; c++) begin
      int n, t0, t1, rises;
      logic prev;
      wr(0, 2'd0, ctrl_byte(0, 1, 3'(c), 1, 0, 0));
      chk("R5 sck_oe master", m_sck_oe, 1'b1);
      wr(0, 2'd2, 8'h00);
      prev = m_sck_o; n = 0; rises = 0; t0 = 0; t1 = 0;
      while (rises < 2 && n < 600) begin
        @(negedge clk); n++;
        if (!prev && m_sck_o) begin
          rises++;
          if (rises == 1) t0 = n; else t1 = n;
        end
        prev = m_sck_o;
      end
      chk($sformatf("R4 period code %0d", c), t1 - t0, exp_div(3'(c)));
      wait_tc_m("R7 tc rate");
      chk("R5 idle low", m_sck_o, 1'b0);
      wr(0, 2'd1, 8'h83);
    end

    // R6 loopback in all four modes, random bytes
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] mb, sb;
        logic [2:0] code, scode;
        logic cpol, cpha;
        cpol = md[1]; cpha = md[0];
        mb = 8'($urandom); sb = 8'($urandom);
        code = 3'(1 + ($urandom % 3));
        scode = 3'($urandom);
        sss_n = 1'b1;
        wr(1, 2'd0, ctrl_byte(0, 1, scode, 0, cpol, cpha));
        wr(1, 2'd1, 8'h00);
        wr(0, 2'd1, 8'h03);
        wr(0, 2'd0, ctrl_byte(1, 1, code, 1, cpol, cpha));
        chk("R5 idle level", m_sck_o, cpol);
        sss_n = 1'b0;
        idle(4);
        wr(1, 2'd2, sb);
        wr(0, 2'd2, mb);
        wait_tc_m("R7 tc loop");
        idle(16);
        rd(0, 2'd2, v); chk($sformatf("R6 master rx mode %0d", md), v, sb);
        rd(1, 2'd2, v); chk($sformatf("R6 slave rx mode %0d", md), v, mb);
        rd(0, 2'd1, v); chk("R3 status after tc", v, 8'h83);
        chk("R7 irq set", m_irq, 1'b1);
        wr(0, 2'd1, 8'h83);
        chk("R7 irq cleared", m_irq, 1'b0);
        wr(1, 2'd1, 8'h80);
        sss_n = 1'b1;
        idle(4);
      end
    end

    // R8 write collision
    wr(1, 2'd0, ctrl_byte(0, 1, 3'b000, 0, 0, 0));
    wr(0, 2'd1, 8'h03);
    wr(0, 2'd0, ctrl_byte(0, 1, 3'b001, 1, 0, 0));
    sss_n = 1'b0; idle(4);
    wr(0, 2'd2, 8'hA5);
    idle(20);
    wr(0, 2'd2, 8'h3C);
    wait_tc_m("R8 tc");
    idle(16);
    rd(0, 2'd1, v); chk("R8 wcol flag", v, 8'hC3);
    rd(1, 2'd2, v); chk("R8 byte unchanged", v, 8'hA5);

    // R9 overrun: slave flag left set
    wr(0, 2'd1, 8'hC3);
    wr(0, 2'd2, 8'h5A);
    wait_tc_m("R9 tc");
    idle(16);
    rd(1, 2'd1, v); chk("R9 ovr flag", v, 8'hA0);
    rd(1, 2'd2, v); chk("R9 byte kept", v, 8'hA5);
    wr(1, 2'd1, 8'hF0);
    rd(1, 2'd1, v); chk("R3 w1c", v, 8'h00);

    // R11 slave MISO drive follows selection
    chk("R11 miso selected", s_miso_oe, 1'b1);
    sss_n = 1'b1; idle(4);
    chk("R11 miso deselected", s_miso_oe, 1'b0);

    // R10 mode fault during a master transfer
    wr(0, 2'd1, 8'hF0);
    wr(0, 2'd0, ctrl_byte(1, 1, 3'b011, 1, 1, 0));
    wr(0, 2'd2, 8'h99);
    idle(40);
    mss_n = 1'b0;
    idle(5);
    rd(0, 2'd0, v); chk("R10 ctrl cleared", v, 8'h8B);
    rd(0, 2'd1, v); chk("R10 modf", v, 8'h10);
    chk("R10 sck_oe off", m_sck_oe, 1'b0);
    chk("R5 sck rests after fault", m_sck_o, 1'b1);
    chk("R7 irq on fault", m_irq, 1'b1);
    mss_n = 1'b1; idle(4);
    wr(0, 2'd1, 8'h10);
    chk("R7 irq after modf clear", m_irq, 1'b0);

    // R11 serial-output disable
    wr(0, 2'd1, 8'h07);
    wr(0, 2'd0, 8'h50);
    chk("R11 mosi_oe with disable", m_mosi_oe, 1'b0);
    chk("R11 sck_oe with disable", m_sck_oe, 1'b1);
    wr(0, 2'd1, 8'h03);
    chk("R11 mosi_oe enabled", m_mosi_oe, 1'b1);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule